// File: doc/BRIEF.md
# Byte-Bus 16-bit Capture Timer

This block is a 16-bit up-counter with one capture register and a parameterized set of compare registers. A CPU reaches it over an 8-bit register bus. Every 16-bit register shows up as a low-byte location and a high-byte location. One shared high-byte latch turns each pair of byte accesses into a single 16-bit access, so software never sees a torn value.

A 3-bit clock-select field chooses how the counter advances:
- it can stop;
- it can step on an internal tick enable, which stands in for a prescaler;
- it can step on a chosen edge of an external clock pin, after that pin is synchronized.

The capture register takes the counter value on a chosen edge of either the capture pin or a comparator input, and sets a capture flag when it does. Each compare register has a sticky match flag. A CPU write to the counter suppresses compare matches on the timer step that follows it.

Top module: `cap_timer16`

## Requirements
- R1: After reset the counter, the capture register, all compare registers, the control register and all flags read zero.
- R2: Byte addresses are: counter low 0, counter high 1, capture low 2, capture high 3, control 4, flags 5, compare k low 6+2k, compare k high 7+2k. A read of a low byte returns that byte and, in the same cycle, copies the register's high byte into the shared latch. A later high-byte read returns the latch, even if the register has changed since.
- R3: A high-byte write only loads the shared latch and leaves the register unchanged. A low-byte write loads the latch value and the written byte into the 16-bit register in one cycle. The latch is common to all 16-bit registers.
- R4: Control bits [2:0] select the clock source. 000 and the unused codes 010–101 hold the counter. 001 adds one for every clock cycle in which tick_en is high. Tick enables are ignored in any other mode.
- R5: Code 111 adds one for each rising edge of ext_clk_pin, and code 110 adds one for each falling edge.
- R6: The counter wraps from 0xFFFF to 0x0000.
- R7: When the counter equals compare register k on a timer step, flag bit k+1 (flags register) and cmp_flag[k] are set.
- R8: A CPU write to the counter prevents every compare unit from matching on the next timer step.
- R9: Flags (bit 0 capture, bit k+1 compare k) stay set until a 1 is written to that bit. Writing 0 to a bit has no effect.
- R10: With control bit 4 = 0, an edge of cap_pin loads the counter into the capture register and sets the capture flag. Control bit 3 = 1 selects the rising edge and 0 selects the falling edge.
- R11: With control bit 4 = 1, comp_in replaces cap_pin as the capture source, and cap_pin edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational, valid while bus_rd) |
| tick_en | input | 1 | Internal timer tick enable |
| ext_clk_pin | input | 1 | External count pin, asynchronous |
| cap_pin | input | 1 | Capture pin, asynchronous |
| comp_in | input | 1 | Comparator output, alternative capture source |
| cap_flag | output | 1 | Capture flag |
| cmp_flag | output | NUM_CMP | Compare match flags |

## Verification
On every cycle the assertions check the counter's local rules:
- it holds when stopped;
- it steps by exactly one with wrap;
- a low-byte write loads the latch and the written byte;
- the suppression state clears after one step;
- a pending suppression never lets a flag rise;
- flags stay sticky until cleared;
- a capture event stores the counter.

Only the bench's scenarios can show the cross-register effects: the latch holds a stale high byte across a step, the latch is shared between the counter and a compare register, edge polarity selection works on the external and capture inputs, the comparator source replaces the pin, and end-to-end counts agree with random write/step sequences.

// File: rtl/cap_timer16_pkg.sv
package cap_timer16_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        CS_STOP     = 3'b000,
        CS_TICK     = 3'b001,
        CS_EXT_FALL = 3'b110,
        CS_EXT_RISE = 3'b111
    } clk_sel_e;

    typedef struct packed {
        logic       cap_src;   // 1: comparator input
        logic       cap_rise;  // 1: rising edge
        logic [2:0] cs;
    } ctrl_t;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd4;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd5;
    localparam int                A_CMP_BASE = 6;

    function automatic logic [ADDR_W-1:0] cmp_lo_addr(input int k);
        return ADDR_W'(A_CMP_BASE + 2 * k);
    endfunction

    function automatic logic [CNT_W-1:0] join_bytes(input logic [DATA_W-1:0] hi,
                                                    input logic [DATA_W-1:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/ct_sync_edge.sv
module ct_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;
    logic              level;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], din};
            last_q <= sh_q[STAGES-1];
        end
    end

    assign level = sh_q[STAGES-1];
    assign rise  = level & ~last_q;
    assign fall  = ~level & last_q;

endmodule

// File: rtl/ct_counter_core.sv
module ct_counter_core
    import cap_timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cs,
    input  logic              tick_en,
    input  logic              ext_rise,
    input  logic              ext_fall,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] temp,
    output logic [CNT_W-1:0]  cnt,
    output logic              cmp_tick,
    output logic              blocked
);
    logic step;

    always_comb begin
        case (clk_sel_e'(cs))
            CS_TICK:     step = tick_en;
            CS_EXT_FALL: step = ext_fall;
            CS_EXT_RISE: step = ext_rise;
            default:     step = 1'b0;
        endcase
    end

    assign cmp_tick = step & ~wr_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            blocked <= 1'b0;
        end else if (wr_lo) begin
            cnt     <= join_bytes(temp, wdata);
            blocked <= 1'b1;
        end else if (step) begin
            cnt     <= cnt + 1'b1;
            blocked <= 1'b0;
        end
    end

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cs == CS_STOP && !wr_lo) |=> $stable(cnt)); // R4
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
        cmp_tick |=> (cnt == CNT_W'($past(cnt) + 1))); // R6
    AST_LO_WR_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (cnt == $past({temp, wdata}))); // R3
    AST_BLOCK_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (blocked && cmp_tick) |=> !blocked); // R8

endmodule

// File: rtl/ct_cmp_unit.sv
module ct_cmp_unit
    import cap_timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] temp,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cmp_tick,
    input  logic              blocked,
    input  logic              flag_clr,
    output logic [CNT_W-1:0]  value,
    output logic              flag
);
    logic match;

    assign match = cmp_tick & ~blocked & (cnt == value);

    always_ff @(posedge clk) begin
        if (rst) begin
            value <= '0;
            flag  <= 1'b0;
        end else begin
            if (wr_lo)
                value <= join_bytes(temp, wdata);
            if (match)
                flag <= 1'b1;
            else if (flag_clr)
                flag <= 1'b0;
        end
    end

    AST_BLOCKED_NO_SET: assert property (@(posedge clk) disable iff (rst)
        (blocked && !flag) |=> !flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flag && !flag_clr) |=> flag); // R9

endmodule

// File: rtl/cap_timer16.sv
module cap_timer16
    import cap_timer16_pkg::*;
#(
    parameter int NUM_CMP     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_en,
    input  logic              ext_clk_pin,
    input  logic              cap_pin,
    input  logic              comp_in,
    output logic              cap_flag,
    output logic [NUM_CMP-1:0] cmp_flag
);
    localparam int FLAG_W = NUM_CMP + 1;

    ctrl_t              ctrl_q;
    logic [DATA_W-1:0]  temp_q;
    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   cap_q;
    logic [CNT_W-1:0]   cmp_val [NUM_CMP];
    logic               cmp_tick, blocked;
    logic               ext_rise, ext_fall, pin_rise, pin_fall, cmpi_rise, cmpi_fall;
    logic               cap_evt;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  latch_src;
    logic               latch_ld;
    logic               hi_wr;
    logic               cnt_wr_lo, cap_wr_lo, flags_wr;
    logic [NUM_CMP-1:0] cmp_wr_lo;
    logic [FLAG_W-1:0]  flag_vec;

    // Input synchronizers
    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_ext (
        .clk(clk), .rst(rst), .din(ext_clk_pin), .rise(ext_rise), .fall(ext_fall));
    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_cap (
        .clk(clk), .rst(rst), .din(cap_pin), .rise(pin_rise), .fall(pin_fall));
    ct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_cmp (
        .clk(clk), .rst(rst), .din(comp_in), .rise(cmpi_rise), .fall(cmpi_fall));

    // Write decode
    assign cnt_wr_lo = bus_wr && (bus_addr == A_CNT_LO);
    assign cap_wr_lo = bus_wr && (bus_addr == A_CAP_LO);
    assign flags_wr  = bus_wr && (bus_addr == A_FLAGS);

    always_comb begin
        hi_wr = bus_wr && ((bus_addr == A_CNT_HI) || (bus_addr == A_CAP_HI));
        for (int k = 0; k < NUM_CMP; k++) begin
            cmp_wr_lo[k] = bus_wr && (bus_addr == cmp_lo_addr(k));
            if (bus_wr && (bus_addr == cmp_lo_addr(k) + 1'b1))
                hi_wr = 1'b1;
        end
    end

    // Counter
    ct_counter_core u_core (
        .clk(clk), .rst(rst), .cs(ctrl_q.cs), .tick_en(tick_en),
        .ext_rise(ext_rise), .ext_fall(ext_fall), .wr_lo(cnt_wr_lo),
        .wdata(bus_wdata), .temp(temp_q), .cnt(cnt),
        .cmp_tick(cmp_tick), .blocked(blocked));

    // Compare units
    genvar g;
    generate
        for (g = 0; g < NUM_CMP; g++) begin : g_cmp
            ct_cmp_unit u_cmp (
                .clk(clk), .rst(rst), .wr_lo(cmp_wr_lo[g]),
                .wdata(bus_wdata), .temp(temp_q), .cnt(cnt),
                .cmp_tick(cmp_tick), .blocked(blocked),
                .flag_clr(flags_wr & bus_wdata[g+1]),
                .value(cmp_val[g]), .flag(cmp_flag[g]));
        end
    endgenerate

    // Capture
    always_comb begin
        if (ctrl_q.cap_src)
            cap_evt = ctrl_q.cap_rise ? cmpi_rise : cmpi_fall;
        else
            cap_evt = ctrl_q.cap_rise ? pin_rise : pin_fall;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q    <= '0;
            cap_flag <= 1'b0;
        end else begin
            if (cap_wr_lo)
                cap_q <= join_bytes(temp_q, bus_wdata);
            else if (cap_evt)
                cap_q <= cnt;
            if (cap_evt)
                cap_flag <= 1'b1;
            else if (flags_wr && bus_wdata[0])
                cap_flag <= 1'b0;
        end
    end

    // Control register and shared high-byte latch
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            temp_q <= '0;
        end else begin
            if (bus_wr && (bus_addr == A_CTRL))
                ctrl_q <= ctrl_t'(bus_wdata[4:0]);
            if (hi_wr)
                temp_q <= bus_wdata;
            else if (latch_ld)
                temp_q <= latch_src;
        end
    end

    // Read mux
    assign flag_vec = {cmp_flag, cap_flag};

    always_comb begin
        rd_mux    = '0;
        latch_src = '0;
        latch_ld  = 1'b0;
        case (bus_addr)
            A_CNT_LO: begin rd_mux = cnt[DATA_W-1:0];   latch_src = cnt[CNT_W-1:DATA_W];   latch_ld = 1'b1; end
            A_CNT_HI: rd_mux = temp_q;
            A_CAP_LO: begin rd_mux = cap_q[DATA_W-1:0]; latch_src = cap_q[CNT_W-1:DATA_W]; latch_ld = 1'b1; end
            A_CAP_HI: rd_mux = temp_q;
            A_CTRL:   rd_mux = DATA_W'(ctrl_q);
            A_FLAGS:  rd_mux = DATA_W'(flag_vec);
            default:  rd_mux = '0;
        endcase
        for (int k = 0; k < NUM_CMP; k++) begin
            if (bus_addr == cmp_lo_addr(k)) begin
                rd_mux    = cmp_val[k][DATA_W-1:0];
                latch_src = cmp_val[k][CNT_W-1:DATA_W];
                latch_ld  = 1'b1;
            end else if (bus_addr == cmp_lo_addr(k) + 1'b1) begin
                rd_mux = temp_q;
            end
        end
        latch_ld = latch_ld & bus_rd;
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cap_evt && !cap_wr_lo) |=> (cap_q == $past(cnt))); // R10
    AST_CAP_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        cap_evt |=> cap_flag); // R10
    AST_HI_WR_LATCH: assert property (@(posedge clk) disable iff (rst)
        hi_wr |=> (temp_q == $past(bus_wdata))); // R3

endmodule

// File: tb/cap_timer16_bench.sv
`timescale 1ns/1ps
module cap_timer16_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       tick_en = 1'b0, ext_clk_pin = 1'b0, cap_pin = 1'b0, comp_in = 1'b0;
    logic       cap_flag;
    logic [1:0] cmp_flag;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    cap_timer16 u_cap_timer16 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en),
        .ext_clk_pin(ext_clk_pin), .cap_pin(cap_pin), .comp_in(comp_in),
        .cap_flag(cap_flag), .cmp_flag(cmp_flag));

    function automatic logic [15:0] exp_after(input logic [15:0] start, input int n);
        return 16'(start + n);
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic wr16(input logic [3:0] lo_a, input logic [15:0] v);
        wr(lo_a + 4'd1, v[15:8]);
        wr(lo_a, v[7:0]);
    endtask

    task automatic rd16(input logic [3:0] lo_a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(lo_a, lo);
        rd(lo_a + 4'd1, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #1 tick_en = 1'b0;
    endtask

    task automatic pulse_ext(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_pin = 1'b1; repeat (4) @(negedge clk);
            ext_clk_pin = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual 0x0000 expected 0x0001");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] v, e;
        logic [7:0]  b;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd16(4'd0, v); chk("R1 counter", v, 16'h0000);
        rd16(4'd2, v); chk("R1 capture", v, 16'h0000);
        rd16(4'd6, v); chk("R1 compare0", v, 16'h0000);
        rd(4'd4, b);   chk("R1 control", {8'h0, b}, 16'h0000);
        rd(4'd5, b);   chk("R1 flags", {8'h0, b}, 16'h0000);

        // R4 stop and reserved codes ignore ticks
        ticks(5);
        rd16(4'd0, v); chk("R4 stopped", v, 16'h0000);
        wr(4'd4, 8'h03);
        ticks(5);
        rd16(4'd0, v); chk("R4 reserved code", v, 16'h0000);
        wr(4'd4, 8'h01);
        ticks(10);
        rd16(4'd0, v); chk("R4 tick count", v, 16'd10);

        // R3 high write alone leaves the counter unchanged
        wr(4'd4, 8'h00);
        wr(4'd1, 8'hAB);
        rd16(4'd0, v); chk("R3 hi write only", v, 16'd10);
        wr16(4'd0, 16'hABCD);
        rd16(4'd0, v); chk("R3 atomic write", v, 16'hABCD);
        // R3 shared latch across registers
        wr(4'd1, 8'h5A);
        wr(4'd6, 8'h33);
        rd16(4'd6, v); chk("R3 shared latch", v, 16'h5A33);

        // R2 stale high byte held in the latch
        wr(4'd4, 8'h01);
        wr16(4'd0, 16'h12FF);
        rd(4'd0, b); chk("R2 low byte", {8'h0, b}, 16'h00FF);
        ticks(1);
        rd(4'd1, b); chk("R2 latched high", {8'h0, b}, 16'h0012);
        rd16(4'd0, v); chk("R2 new value", v, 16'h1300);

        // R6 wrap
        wr16(4'd0, 16'hFFFF);
        ticks(1);
        rd16(4'd0, v); chk("R6 wrap", v, 16'h0000);

        // R7 compare matches
        wr(4'd5, 8'h07);
        wr16(4'd6, 16'h0100);
        wr16(4'd8, 16'h0102);
        wr16(4'd0, 16'h00FE);
        ticks(3);
        @(negedge clk); chk("R7 cmp0 only", {14'h0, cmp_flag}, 16'h0001);
        ticks(2);
        @(negedge clk); chk("R7 both", {14'h0, cmp_flag}, 16'h0003);
        rd(4'd5, b); chk("R7 flags reg", {8'h0, b}, 16'h0006);

        // R9 write one to clear
        wr(4'd5, 8'h00);
        rd(4'd5, b); chk("R9 zero write", {8'h0, b}, 16'h0006);
        wr(4'd5, 8'h02);
        rd(4'd5, b); chk("R9 clear cmp0", {8'h0, b}, 16'h0004);
        wr(4'd5, 8'h04);
        rd(4'd5, b); chk("R9 clear cmp1", {8'h0, b}, 16'h0000);

        // R8 write to counter suppresses next match
        wr16(4'd0, 16'h0100);
        ticks(1);
        @(negedge clk); chk("R8 cmp0 blocked", {14'h0, cmp_flag}, 16'h0000);
        wr16(4'd0, 16'h0102);
        ticks(1);
        @(negedge clk); chk("R8 cmp1 blocked", {14'h0, cmp_flag}, 16'h0000);
        rd16(4'd0, v); chk("R8 still counts", v, 16'h0103);
        wr16(4'd0, 16'h00FF);
        ticks(2);
        @(negedge clk); chk("R8 later match", {14'h0, cmp_flag}, 16'h0001);

        // R5 external clock pin
        wr(4'd4, 8'h07);
        wr16(4'd0, 16'h0000);
        pulse_ext(5);
        rd16(4'd0, v); chk("R5 rising edges", v, 16'd5);
        wr(4'd4, 8'h06);
        wr16(4'd0, 16'h0000);
        ticks(4);
        pulse_ext(3);
        rd16(4'd0, v); chk("R5 falling edges, ticks ignored", v, 16'd3);

        // R10 capture pin
        wr(4'd4, 8'h08);
        wr(4'd5, 8'h01);
        wr16(4'd0, 16'h4321);
        cap_pin = 1'b1; repeat (6) @(negedge clk);
        cap_pin = 1'b0; repeat (6) @(negedge clk);
        rd16(4'd2, v); chk("R10 rising capture", v, 16'h4321);
        chk("R10 capture flag", {15'h0, cap_flag}, 16'h0001);
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h01);
        wr16(4'd0, 16'h1111);
        cap_pin = 1'b1; repeat (6) @(negedge clk);
        rd16(4'd2, v); chk("R10 rise ignored in falling mode", v, 16'h4321);
        chk("R10 no flag", {15'h0, cap_flag}, 16'h0000);
        cap_pin = 1'b0; repeat (6) @(negedge clk);
        rd16(4'd2, v); chk("R10 falling capture", v, 16'h1111);

        // R11 comparator as capture source
        wr(4'd4, 8'h18);
        wr16(4'd0, 16'h2222);
        cap_pin = 1'b1; repeat (6) @(negedge clk);
        cap_pin = 1'b0; repeat (6) @(negedge clk);
        rd16(4'd2, v); chk("R11 pin ignored", v, 16'h1111);
        comp_in = 1'b1; repeat (6) @(negedge clk);
        comp_in = 1'b0; repeat (6) @(negedge clk);
        rd16(4'd2, v); chk("R11 comparator capture", v, 16'h2222);

        // R2 R3 R4 random write and step sequences
        wr(4'd4, 8'h01);
        for (int i = 0; i < 30; i++) begin
            logic [15:0] start;
            int n;
            start = 16'($urandom);
            n = $urandom_range(1, 12);
            wr16(4'd0, start);
            ticks(n);
            e = exp_after(start, n);
            rd16(4'd0, v); chk("R4 random steps", v, e);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule